// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave device has left stuck, usually with SDA held low partway through a byte. A single trigger starts it. It samples the live SCL and SDA levels through a synchroniser. If both lines read high, it reports completion at once and does nothing else. If either line is low, it issues single SCL clock pulses through a one-shot toggle request. After each pulse it waits a settle interval and then samples SDA again. Pulsing stops as soon as SDA reads high, or once a fixed pulse budget is spent.

When SDA is released, the block asks the master controller for a START condition and presents a write-direction address byte with it. After one settle interval it requests a STOP, which returns the bus to idle. It then waits a longer idle interval. Whether recovery succeeds or fails, the sequence ends with a one-cycle reset request to the master controller's state logic. At the same moment the block raises done together with either success or fail. Every delay is counted in clock cycles, and the cycle counts are derived from a clock-frequency parameter, so the microsecond intervals hold at any clock rate.

Top module: `i2c_bus_recovery`

## Requirements
- R1: While reset is asserted, every output is 0, including `addr_byte_o`.
- R2: Skip case. If both synchronised lines are high, the block raises `done_o` for one cycle on the clock edge after the edge that captures `recover_i`. The lines must have been stable for at least three cycles. `success_o`, `fail_o`, `ctrl_reset_o`, `scl_pulse_o`, `start_req_o` and `stop_req_o` all stay low.
- R3: If either line is low at the check, the first `scl_pulse_o` comes on that same edge. Each pulse lasts one cycle, and consecutive pulses are exactly SETTLE cycles apart. SETTLE is CLK_HZ/1000*SETTLE_US/1000 cycles. At most one of `scl_pulse_o`, `start_req_o` and `stop_req_o` is high in any cycle.
- R4: SETTLE cycles after each pulse, the block samples SDA. If SDA reads high, it issues no further pulse and raises `start_req_o` at that point. A slave that releases SDA after N pulses, where N is at most MAX_PULSES, therefore sees exactly N pulses.
- R5: If SDA is still low when the pulse count reaches MAX_PULSES, the block raises `fail_o` with `done_o` SETTLE cycles after the last pulse. No START or STOP is requested.
- R6: While `start_req_o` is high, `addr_byte_o` equals {address, 0}. The address is the value of `addr_i` captured with the trigger, placed in bits 7..1, and bit 0 is the write direction.
- R7: `stop_req_o` rises exactly SETTLE cycles after `start_req_o`. `done_o` and `success_o` follow `stop_req_o` by exactly IDLE cycles, where IDLE is CLK_HZ/1000*IDLE_US/1000.
- R8: `ctrl_reset_o` pulses for one cycle, in the same cycle as `done_o`, on both the success path and the failure path.
- R9: `success_o` and `fail_o` are never high together. Each is a one-cycle pulse that coincides with `done_o`.
- R10: A trigger that arrives while a sequence is running is ignored. It changes neither the address byte nor the pulse count, and it produces no second `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| recover_i | input | 1 | Starts a recovery sequence when idle |
| addr_i | input | 7 | Target address used for the closing START |
| scl_sense_i | input | 1 | Live SCL level (asynchronous) |
| sda_sense_i | input | 1 | Live SDA level (asynchronous) |
| scl_pulse_o | output | 1 | One-cycle request to toggle SCL once |
| start_req_o | output | 1 | One-cycle request for a START condition |
| stop_req_o | output | 1 | One-cycle request for a STOP condition |
| addr_byte_o | output | 8 | Address byte to transmit with the START |
| ctrl_reset_o | output | 1 | One-cycle reset request for the master controller |
| done_o | output | 1 | Sequence finished (one cycle) |
| success_o | output | 1 | Bus released and STOP issued (one cycle, with done) |
| fail_o | output | 1 | Pulse budget exhausted (one cycle, with done) |

## Verification
The sweep holds SDA low and lets a modelled slave release it after 1 to 30 pulses, plus a case where it never releases. These runs separate an off-by-one in the pulse budget at the 28/29 boundary from a wrong sampling point after each pulse. Separate runs cover SCL low alone, both lines low, and both lines high. Together they distinguish the "either line low" entry test from the skip path. A run that re-triggers mid-sequence with a different address checks that the address is latched and that busy triggers are dropped. The gaps between pulse, START, STOP and done are measured against SETTLE and IDLE values computed from the clock parameter.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SETTLE,
        ST_HOLD_START,
        ST_HOLD_STOP
    } state_e;

    // Whole cycles in a microsecond interval at the given clock rate.
    function automatic int unsigned us_to_cycles(int unsigned hz, int unsigned us);
        return (hz / 1000) * us / 1000;
    endfunction

endpackage

// File: rtl/i2crec_sync.sv
module i2crec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Lines idle high, so the chain resets to ones.
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[g] <= '1;
                else         stg_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[g] <= '1;
                else         stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2crec_timer.sv
module i2crec_timer #(
    parameter int W = 14
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R7

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R3
endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery
    import i2crec_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned SETTLE_US   = 20,
    parameter int unsigned IDLE_US     = 200,
    parameter int unsigned MAX_PULSES  = 28,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       recover_i,
    input  logic [6:0] addr_i,
    input  logic       scl_sense_i,
    input  logic       sda_sense_i,
    output logic       scl_pulse_o,
    output logic       start_req_o,
    output logic       stop_req_o,
    output logic [7:0] addr_byte_o,
    output logic       ctrl_reset_o,
    output logic       done_o,
    output logic       success_o,
    output logic       fail_o
);
    localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_HZ, SETTLE_US);
    localparam int unsigned IDLE_CYC   = us_to_cycles(CLK_HZ, IDLE_US);
    localparam int unsigned LONGEST    = (IDLE_CYC > SETTLE_CYC) ? IDLE_CYC : SETTLE_CYC;
    localparam int TW = $clog2(LONGEST + 1);
    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] IDLE_LOAD   = TW'(IDLE_CYC - 1);
    localparam logic [CW-1:0] PULSE_LIM   = CW'(MAX_PULSES);

    typedef struct packed {
        state_e        state;
        logic [CW-1:0] npulse;
        logic [6:0]    addr;
        logic          scl_pulse;
        logic          start_req;
        logic          stop_req;
        logic          ctrl_rst;
        logic          done;
        logic          ok;
        logic          fail;
    } regs_t;

    regs_t d, q;

    logic [1:0]    lines_s;
    logic          scl_s, sda_s;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    i2crec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({scl_sense_i, sda_sense_i}),
        .q_o    (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2crec_timer #(.W(TW)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    always_comb begin
        d           = q;
        d.scl_pulse = 1'b0;
        d.start_req = 1'b0;
        d.stop_req  = 1'b0;
        d.ctrl_rst  = 1'b0;
        d.done      = 1'b0;
        d.ok        = 1'b0;
        d.fail      = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = SETTLE_LOAD;

        case (q.state)
            ST_IDLE: begin
                if (recover_i) begin
                    d.addr   = addr_i;
                    d.npulse = '0;
                    d.state  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (scl_s && sda_s) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.scl_pulse = 1'b1;
                    d.npulse    = CW'(1);
                    tmr_load    = 1'b1;
                    d.state     = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    if (sda_s) begin
                        d.start_req = 1'b1;
                        tmr_load    = 1'b1;
                        d.state     = ST_HOLD_START;
                    end else if (q.npulse >= PULSE_LIM) begin
                        d.ctrl_rst = 1'b1;
                        d.done     = 1'b1;
                        d.fail     = 1'b1;
                        d.state    = ST_IDLE;
                    end else begin
                        d.scl_pulse = 1'b1;
                        d.npulse    = q.npulse + CW'(1);
                        tmr_load    = 1'b1;
                    end
                end
            end
            ST_HOLD_START: begin
                if (tmr_exp) begin
                    d.stop_req = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = IDLE_LOAD;
                    d.state    = ST_HOLD_STOP;
                end
            end
            ST_HOLD_STOP: begin
                if (tmr_exp) begin
                    d.ctrl_rst = 1'b1;
                    d.done     = 1'b1;
                    d.ok       = 1'b1;
                    d.state    = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{state: ST_IDLE, npulse: '0, addr: '0, default: 1'b0};
        else         q <= d;
    end

    assign scl_pulse_o  = q.scl_pulse;
    assign start_req_o  = q.start_req;
    assign stop_req_o   = q.stop_req;
    assign addr_byte_o  = {q.addr, 1'b0};
    assign ctrl_reset_o = q.ctrl_rst;
    assign done_o       = q.done;
    assign success_o    = q.ok;
    assign fail_o       = q.fail;

    AST_OK_FAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(success_o && fail_o)); // R9

    AST_FLAG_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (success_o || fail_o) |-> done_o); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9

    AST_RST_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_reset_o |-> (done_o && (success_o || fail_o))); // R8

    AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.npulse <= PULSE_LIM); // R5

    AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({scl_pulse_o, start_req_o, stop_req_o})); // R3

    AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state != ST_IDLE && d.state != ST_CHECK) |=> $stable(addr_byte_o)); // R10
endmodule

// File: tb/i2c_bus_recovery_tb.sv
module i2c_bus_recovery_tb;
    localparam int HZ   = 1_000_000;
    localparam int SU   = 20;
    localparam int IU   = 200;
    localparam int MAXP = 28;
    localparam int S    = (HZ / 1000) * SU / 1000;
    localparam int L    = (HZ / 1000) * IU / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [6:0] addr = '0;
    logic       scl_line = 1'b1;
    logic       sda_line = 1'b1;
    logic       scl_pulse, start_req, stop_req, ctrl_rst, done, success, fail;
    logic [7:0] addr_byte;

    i2c_bus_recovery #(
        .CLK_HZ(HZ), .SETTLE_US(SU), .IDLE_US(IU), .MAX_PULSES(MAXP), .SYNC_STAGES(2)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .recover_i(trig), .addr_i(addr),
        .scl_sense_i(scl_line), .sda_sense_i(sda_line),
        .scl_pulse_o(scl_pulse), .start_req_o(start_req), .stop_req_o(stop_req),
        .addr_byte_o(addr_byte), .ctrl_reset_o(ctrl_rst), .done_o(done),
        .success_o(success), .fail_o(fail)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    int npulse, nstart, nstop, ndone, nrst, nok, nfail, rel_n;
    int t_last, t_start, t_stop, t_done;
    bit gap_bad, ok_at, fail_at, rst_at;
    logic [7:0] byte_seen;

    // Slave model and event recorder
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_pulse) begin
                if (npulse > 0 && (cyc - t_last) != S) gap_bad = 1'b1;
                npulse++;
                t_last = cyc;
                if (npulse >= rel_n) begin
                    sda_line = 1'b1;
                    scl_line = 1'b1;
                end
            end
            if (start_req) begin nstart++; t_start = cyc; byte_seen = addr_byte; end
            if (stop_req)  begin nstop++;  t_stop = cyc; end
            if (ctrl_rst)  nrst++;
            if (success)   nok++;
            if (fail)      nfail++;
            if (done) begin
                ndone++;
                t_done  = cyc;
                ok_at   = success;
                fail_at = fail;
                rst_at  = ctrl_rst;
            end
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int rel, input logic [6:0] a, input bit scl_low,
                       input bit sda_low, input bit poke);
        int t_trig;
        int g;
        int exp_p;
        @(negedge clk);
        npulse = 0; nstart = 0; nstop = 0; ndone = 0; nrst = 0; nok = 0; nfail = 0;
        gap_bad = 0; ok_at = 0; fail_at = 0; rst_at = 0; byte_seen = '0;
        t_last = 0; t_start = 0; t_stop = 0; t_done = 0;
        rel_n = rel;
        scl_line = !scl_low;
        sda_line = !sda_low;
        addr = a;
        repeat (4) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        t_trig = cyc;
        addr = ~a;
        if (poke) begin
            repeat (5) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        g = 0;
        while (ndone == 0 && g < 3000) begin
            @(negedge clk);
            g++;
        end
        repeat (40) @(negedge clk);

        if (!scl_low && !sda_low) begin
            check(ndone == 1, "R2 done count", ndone, 1);
            check(t_done - t_trig == 1, "R2 done latency", t_done - t_trig, 1);
            check(npulse == 0 && nstart == 0 && nstop == 0, "R2 no bus activity",
                  npulse + nstart + nstop, 0);
            check(nrst == 0 && nok == 0 && nfail == 0, "R2 no flags", nrst + nok + nfail, 0);
        end else begin
            exp_p = (rel <= MAXP) ? rel : MAXP;
            check(npulse == exp_p, "R4 R5 pulse count", npulse, exp_p);
            check(!gap_bad, "R3 pulse spacing", gap_bad, 0);
            check(ndone == 1, "R10 single done", ndone, 1);
            check(rst_at && nrst == 1, "R8 reset with done", nrst, 1);
            check(nok + nfail == 1 && ok_at != fail_at, "R9 exclusive flags", nok + nfail, 1);
            if (rel <= MAXP) begin
                check(ok_at, "R4 success", ok_at, 1);
                check(nstart == 1 && nstop == 1, "R7 start and stop", nstart + nstop, 2);
                check(t_start - t_last == S, "R4 start after last pulse", t_start - t_last, S);
                check(t_stop - t_start == S, "R7 stop gap", t_stop - t_start, S);
                check(t_done - t_stop == L, "R7 idle gap", t_done - t_stop, L);
                check(byte_seen == {a, 1'b0}, "R6 address byte", byte_seen, {a, 1'b0});
            end else begin
                check(fail_at, "R5 fail flag", fail_at, 1);
                check(nstart == 0 && nstop == 0, "R5 no start/stop", nstart + nstop, 0);
                check(t_done - t_last == S, "R5 fail timing", t_done - t_last, S);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({scl_pulse, start_req, stop_req, ctrl_rst, done, success, fail} == '0,
              "R1 outputs in reset", {scl_pulse, start_req, stop_req, ctrl_rst, done, success, fail}, 0);
        check(addr_byte == 8'h00, "R1 addr byte in reset", addr_byte, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run(1, 7'h2A, 1'b0, 1'b0, 1'b0);       // R2 skip
        for (int n = 1; n <= 30; n++)          // R4 R5 sweep
            run(n, 7'(n * 37), 1'b0, 1'b1, 1'b0);
        run(1000, 7'h7F, 1'b0, 1'b1, 1'b0);    // R5 never released
        run(1, 7'h11, 1'b1, 1'b0, 1'b0);       // R3 SCL low only
        run(5, 7'h40, 1'b1, 1'b1, 1'b0);       // R3 both low
        run(3, 7'h5C, 1'b0, 1'b1, 1'b1);       // R10 busy re-trigger
        run(1, 7'h01, 1'b0, 1'b0, 1'b0);       // R2 skip again

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule